// File: doc/BRIEF.md
# Dual-Issue Pairing and Stall Control

This block sits between instruction decode and two in-order integer pipelines. Each cycle it looks at the two oldest decoded descriptors, slot A (older) and slot B (younger). It decides whether nothing, A alone, or A and B together leave the queue this cycle, and which pipeline the consumed descriptor enters. A descriptor carries up to two source registers, each with the execute stage that reads it. It also carries a destination register mask with the stage that produces the result, plus flags for memory access and load-to-PC, a load-multiple register count and a register-offset shift amount.

A per-register scoreboard holds the distance, in cycles, to the point where each pending result can be consumed. Operand timing is therefore judged per stage, not as a plain dependency test. Multi-cycle instructions (loads to the PC, load-multiples, awkward shifts) move a small state machine from `ST_ISSUE` to `ST_HOLD` (transition "start multi-cycle") for the extra cycles. In the last held cycle the next single-cycle, non-memory instruction may enter pipeline 1, and the machine returns to `ST_ISSUE` (transition "release"). Otherwise it stays in `ST_HOLD` (transition "count down"). The consumer takes a descriptor from A when `take_old` is high and from B when `take_young` is high.

Top module: `dual_issue_ctl`

## Requirements
- R1: In `ST_ISSUE`, a consumed slot A always enters pipeline 0 (`old_pipe`=0), alone or with slot B, and a consumed slot B enters pipeline 1.
- R2: Stage codes are 1=E1, 2=E2, 3=E3 and 0=unused. B does not pair with A when a B source register is in A's destination mask and B's need stage is less than or equal to A's produce stage. This covers E2 produced and E2 needed.
- R3: The scoreboard bit for a register is set from the destination mask. A source is ready only when the cycles left until its result is available are fewer than its need-stage code. A result produced in E3 and needed in E1 by the next instruction gives exactly two stall cycles with `stall`=1, and issue on the third.
- R4: A store whose data register (need stage E3) comes from an E3 result of the instruction issued one cycle earlier issues without delay.
- R5: When both A and B have the memory-access flag set, only A is taken.
- R6: A load to the PC takes 2 cycles. In its second cycle, the following single-cycle instruction may be taken into pipeline 1.
- R7: A shift amount of 0 or 2 adds no cycle. Any other nonzero shift amount adds one cycle.
- R8: A load-multiple of n registers (n≥1) takes 1 + floor(n/2) cycles, so 4 registers take 3 cycles.
- R9: In the last cycle of a multi-cycle instruction, only a ready, single-cycle, non-memory instruction is taken, into pipeline 1. Any other waits, and it is taken in pipeline 0 on the next cycle.
- R10: Issue is in order. `take_young` is never high without `take_old`, and a stalled A blocks B.
- R11: Reset or `flush` clears the scoreboard and any multi-cycle hold. Nothing is taken during a flush cycle.
- R12: A multi-cycle instruction never pairs in its first cycle, neither as A nor as B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Pipeline flush, clears scoreboard and hold |
| a_vld | input | 1 | Slot A (older) holds a descriptor |
| a_src0 | input | RW | Slot A first source register |
| a_stg0 | input | 2 | Slot A first source need stage (0 = unused) |
| a_src1 | input | RW | Slot A second source register |
| a_stg1 | input | 2 | Slot A second source need stage |
| a_dmask | input | NREG | Slot A destination register mask |
| a_dstg | input | 2 | Slot A result produce stage |
| a_ls | input | 1 | Slot A uses the load/store unit |
| a_pcld | input | 1 | Slot A loads the PC |
| a_ldm | input | LW | Slot A load-multiple count (0 = not one) |
| a_shamt | input | SHW | Slot A register-offset shift amount |
| b_vld | input | 1 | Slot B (younger) holds a descriptor |
| b_src0 | input | RW | Slot B first source register |
| b_stg0 | input | 2 | Slot B first source need stage |
| b_src1 | input | RW | Slot B second source register |
| b_stg1 | input | 2 | Slot B second source need stage |
| b_dmask | input | NREG | Slot B destination register mask |
| b_dstg | input | 2 | Slot B result produce stage |
| b_ls | input | 1 | Slot B uses the load/store unit |
| b_pcld | input | 1 | Slot B loads the PC |
| b_ldm | input | LW | Slot B load-multiple count |
| b_shamt | input | SHW | Slot B shift amount |
| take_old | output | 1 | Slot A consumed this cycle |
| take_young | output | 1 | Slot B consumed this cycle (pipeline 1) |
| old_pipe | output | 1 | Pipeline index for slot A when taken |
| stall | output | 1 | Slot A valid but held back by an operand |
| hold | output | 1 | A multi-cycle instruction occupies pipeline 0 |

## Verification
The assertions assume that a nonzero destination mask always comes with a produce stage of 1 to 3. They also assume the consumer removes exactly the slots reported taken before the next edge, so the descriptor in slot A during a hold is the one that follows the held instruction. The bench drives only such well-formed descriptors. It changes inputs only on falling edges and presents a fresh slot A after every take, the way a real queue would shift. Flushes start each table vector, so every vector is judged from an empty scoreboard in `ST_ISSUE`.

// File: rtl/di_pkg.sv
package di_pkg;

    // Issue-control state machine.
    typedef enum logic [0:0] {
        ST_ISSUE = 1'b0,
        ST_HOLD  = 1'b1
    } di_state_e;

    // Stage code meaning "operand not used".
    localparam logic [1:0] STG_NONE = 2'd0;

    // Cycles from issue until a result of stage code stg can be consumed,
    // measured from the cycle after issue.
    function automatic logic [1:0] stg_wait(input logic [1:0] stg);
        return (stg == STG_NONE) ? 2'd0 : stg - 2'd1;
    endfunction

endpackage

// File: rtl/di_cost.sv
// Number of issue cycles a descriptor occupies pipeline 0 for.
module di_cost #(
    parameter int LW  = 5,
    parameter int SHW = 5,
    parameter int CW  = 4
) (
    input  logic           pcld,
    input  logic [LW-1:0]  ldm_n,
    input  logic [SHW-1:0] shamt,
    output logic [CW-1:0]  cycles
);
    logic [CW-1:0] base;
    logic          extra;

    always_comb begin
        if (ldm_n != '0)
            base = CW'(1) + CW'(ldm_n >> 1);
        else if (pcld)
            base = CW'(2);
        else
            base = CW'(1);
        extra  = (shamt != '0) && (shamt != SHW'(2));
        cycles = base + CW'(extra);
    end
endmodule

// File: rtl/di_scoreboard.sv
// Per-register countdown to the cycle a pending result becomes usable.
module di_scoreboard
    import di_pkg::*;
#(
    parameter int NREG = 16,
    parameter int NQ   = 4,
    localparam int RW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            set_a,
    input  logic [NREG-1:0] a_dmask,
    input  logic [1:0]      a_dstg,
    input  logic            set_b,
    input  logic [NREG-1:0] b_dmask,
    input  logic [1:0]      b_dstg,
    input  logic [RW-1:0]   q_idx [NQ],
    input  logic [1:0]      q_stg [NQ],
    output logic [NQ-1:0]   q_ok
);
    logic [1:0]      sb_q [NREG];
    logic [NREG-1:0] pend;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sb_q[r] <= 2'd0;
            else if (flush)
                sb_q[r] <= 2'd0;
            else if (set_b && b_dmask[r])
                sb_q[r] <= stg_wait(b_dstg);
            else if (set_a && a_dmask[r])
                sb_q[r] <= stg_wait(a_dstg);
            else if (sb_q[r] != 2'd0)
                sb_q[r] <= sb_q[r] - 2'd1;
        end
        assign pend[r] = (sb_q[r] != 2'd0);

        // Countdown never exceeds the longest produce stage.
        assert_sb_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
            sb_q[r] != 2'd3);
    end

    for (genvar q = 0; q < NQ; q++) begin : g_query
        assign q_ok[q] = (q_stg[q] == STG_NONE) || (sb_q[q_idx[q]] < q_stg[q]);
    end

    assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (pend == '0));

endmodule

// File: rtl/dual_issue_ctl.sv
module dual_issue_ctl
    import di_pkg::*;
#(
    parameter int NREG = 16,
    parameter int SHW  = 5,
    localparam int RW  = $clog2(NREG),
    localparam int LW  = $clog2(NREG + 1),
    localparam int CW  = $clog2(NREG / 2 + 3)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            a_vld,
    input  logic [RW-1:0]   a_src0,
    input  logic [1:0]      a_stg0,
    input  logic [RW-1:0]   a_src1,
    input  logic [1:0]      a_stg1,
    input  logic [NREG-1:0] a_dmask,
    input  logic [1:0]      a_dstg,
    input  logic            a_ls,
    input  logic            a_pcld,
    input  logic [LW-1:0]   a_ldm,
    input  logic [SHW-1:0]  a_shamt,
    input  logic            b_vld,
    input  logic [RW-1:0]   b_src0,
    input  logic [1:0]      b_stg0,
    input  logic [RW-1:0]   b_src1,
    input  logic [1:0]      b_stg1,
    input  logic [NREG-1:0] b_dmask,
    input  logic [1:0]      b_dstg,
    input  logic            b_ls,
    input  logic            b_pcld,
    input  logic [LW-1:0]   b_ldm,
    input  logic [SHW-1:0]  b_shamt,
    output logic            take_old,
    output logic            take_young,
    output logic            old_pipe,
    output logic            stall,
    output logic            hold
);
    localparam int NSLOT = 2;
    localparam int NQ    = 2 * NSLOT;

    di_state_e     st_q, st_d;
    logic [CW-1:0] rem_q, rem_d;

    // ---- per-slot cycle cost ----
    logic          pcld_v [NSLOT];
    logic [LW-1:0] ldm_v  [NSLOT];
    logic [SHW-1:0] sh_v  [NSLOT];
    logic [CW-1:0] cyc_v  [NSLOT];

    assign pcld_v[0] = a_pcld;
    assign pcld_v[1] = b_pcld;
    assign ldm_v[0]  = a_ldm;
    assign ldm_v[1]  = b_ldm;
    assign sh_v[0]   = a_shamt;
    assign sh_v[1]   = b_shamt;

    for (genvar g = 0; g < NSLOT; g++) begin : g_cost
        di_cost #(.LW(LW), .SHW(SHW), .CW(CW)) u_cost (
            .pcld  (pcld_v[g]),
            .ldm_n (ldm_v[g]),
            .shamt (sh_v[g]),
            .cycles(cyc_v[g])
        );
    end

    logic a_multi, b_multi;
    assign a_multi = (cyc_v[0] != CW'(1));
    assign b_multi = (cyc_v[1] != CW'(1));

    // ---- scoreboard operand checks ----
    logic [RW-1:0] q_idx [NQ];
    logic [1:0]    q_stg [NQ];
    logic [NQ-1:0] q_ok;

    assign q_idx[0] = a_src0;
    assign q_idx[1] = a_src1;
    assign q_idx[2] = b_src0;
    assign q_idx[3] = b_src1;
    assign q_stg[0] = a_stg0;
    assign q_stg[1] = a_stg1;
    assign q_stg[2] = b_stg0;
    assign q_stg[3] = b_stg1;

    di_scoreboard #(.NREG(NREG), .NQ(NQ)) u_sb (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .set_a  (take_old),
        .a_dmask(a_dmask),
        .a_dstg (a_dstg),
        .set_b  (take_young),
        .b_dmask(b_dmask),
        .b_dstg (b_dstg),
        .q_idx  (q_idx),
        .q_stg  (q_stg),
        .q_ok   (q_ok)
    );

    logic a_rdy, b_rdy;
    assign a_rdy = q_ok[0] && q_ok[1];
    assign b_rdy = q_ok[2] && q_ok[3];

    // ---- same-cycle hazard of B on A's results ----
    logic pair_haz;
    always_comb begin
        pair_haz = 1'b0;
        if (b_stg0 != STG_NONE && a_dmask[b_src0] && b_stg0 <= a_dstg)
            pair_haz = 1'b1;
        if (b_stg1 != STG_NONE && a_dmask[b_src1] && b_stg1 <= a_dstg)
            pair_haz = 1'b1;
    end

    logic can_pair;
    assign can_pair = b_vld && b_rdy && !b_multi && !pair_haz && !(a_ls && b_ls);

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_ISSUE;
            rem_q <= '0;
        end else begin
            st_q  <= st_d;
            rem_q <= rem_d;
        end
    end

    // ---- next state and outputs ----
    always_comb begin
        st_d       = st_q;
        rem_d      = rem_q;
        take_old   = 1'b0;
        take_young = 1'b0;
        old_pipe   = 1'b0;
        stall      = 1'b0;
        if (flush) begin
            st_d  = ST_ISSUE;
            rem_d = '0;
        end else begin
            unique case (st_q)
                ST_ISSUE: begin
                    if (a_vld && a_rdy) begin
                        take_old = 1'b1;
                        if (a_multi) begin
                            st_d  = ST_HOLD;
                            rem_d = cyc_v[0] - CW'(1);
                        end else begin
                            take_young = can_pair;
                        end
                    end else begin
                        stall = a_vld;
                    end
                end
                ST_HOLD: begin
                    if (rem_q == CW'(1)) begin
                        st_d  = ST_ISSUE;
                        rem_d = '0;
                        if (a_vld && a_rdy && !a_multi && !a_ls) begin
                            take_old = 1'b1;
                            old_pipe = 1'b1;
                        end
                    end else begin
                        rem_d = rem_q - CW'(1);
                    end
                end
                default: begin
                    st_d  = ST_ISSUE;
                    rem_d = '0;
                end
            endcase
        end
    end

    assign hold = (st_q == ST_HOLD);

    // ---- assertions ----
    assert_in_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_young |-> take_old);

    assert_one_ls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_young |-> !(a_ls && b_ls));

    assert_pipe1_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_old && old_pipe) |-> (!take_young && !a_ls && hold));

    assert_multi_alone_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (take_old && a_multi) |-> !take_young);

    assert_multi_enters_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_old && a_multi && !hold && !flush) |=> hold);

    assert_flush_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!take_old && !take_young));

    assert_pair_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_young && b_stg0 != STG_NONE && a_dmask[b_src0]) |-> (b_stg0 > a_dstg));

endmodule

// File: tb/dual_issue_ctl_tb_top.sv
module dual_issue_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic [3:0]  s0;
        logic [1:0]  t0;
        logic [3:0]  s1;
        logic [1:0]  t1;
        logic [15:0] dm;
        logic [1:0]  dt;
        logic        ls;
        logic        pc;
        logic [4:0]  ldm;
        logic [4:0]  sh;
    } desc_t;

    typedef struct packed {
        desc_t      a;
        desc_t      b;
        logic       eo;
        logic       ey;
        logic [3:0] rq;
    } vec_t;

    localparam desc_t NOP = '0;

    // Pairing vectors from an empty scoreboard: {A, B, take_old, take_young, req}
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // R1 independent ALU pair
        '{'{4'd1,2'd1,4'd0,2'd0,16'h0004,2'd1,1'b0,1'b0,5'd0,5'd0},
          '{4'd3,2'd1,4'd0,2'd0,16'h0010,2'd1,1'b0,1'b0,5'd0,5'd0}, 1'b1, 1'b1, 4'd1},
        // R2 E2 produced, E2 needed
        '{'{4'd1,2'd1,4'd0,2'd0,16'h0004,2'd2,1'b0,1'b0,5'd0,5'd0},
          '{4'd2,2'd2,4'd0,2'd0,16'h0010,2'd1,1'b0,1'b0,5'd0,5'd0}, 1'b1, 1'b0, 4'd2},
        // R2 E1 produced, E2 needed
        '{'{4'd1,2'd1,4'd0,2'd0,16'h0004,2'd1,1'b0,1'b0,5'd0,5'd0},
          '{4'd2,2'd2,4'd0,2'd0,16'h0010,2'd1,1'b0,1'b0,5'd0,5'd0}, 1'b1, 1'b1, 4'd2},
        // R5 two memory ops
        '{'{4'd6,2'd1,4'd0,2'd0,16'h0001,2'd3,1'b1,1'b0,5'd0,5'd0},
          '{4'd1,2'd1,4'd0,2'd0,16'h0000,2'd0,1'b1,1'b0,5'd0,5'd0}, 1'b1, 1'b0, 4'd5},
        // R5 memory op with ALU
        '{'{4'd6,2'd1,4'd0,2'd0,16'h0001,2'd3,1'b1,1'b0,5'd0,5'd0},
          '{4'd3,2'd1,4'd0,2'd0,16'h0010,2'd1,1'b0,1'b0,5'd0,5'd0}, 1'b1, 1'b1, 4'd5},
        // R6 PC load does not pair in first cycle
        '{'{4'd13,2'd1,4'd0,2'd0,16'h0000,2'd0,1'b1,1'b1,5'd0,5'd0},
          '{4'd3,2'd1,4'd0,2'd0,16'h0010,2'd1,1'b0,1'b0,5'd0,5'd0}, 1'b1, 1'b0, 4'd6},
        // R7 odd shift makes B multi-cycle
        '{'{4'd1,2'd1,4'd0,2'd0,16'h0004,2'd1,1'b0,1'b0,5'd0,5'd0},
          '{4'd1,2'd1,4'd7,2'd1,16'h0000,2'd0,1'b1,1'b0,5'd0,5'd3}, 1'b1, 1'b0, 4'd7},
        // R7 shift by 2 stays single cycle
        '{'{4'd1,2'd1,4'd2,2'd1,16'h0001,2'd3,1'b1,1'b0,5'd0,5'd2},
          '{4'd3,2'd1,4'd0,2'd0,16'h0010,2'd1,1'b0,1'b0,5'd0,5'd0}, 1'b1, 1'b1, 4'd7},
        // R2 E3 produced, E3 needed in same cycle
        '{'{4'd1,2'd1,4'd0,2'd0,16'h0020,2'd3,1'b0,1'b0,5'd0,5'd0},
          '{4'd5,2'd3,4'd0,2'd0,16'h0000,2'd0,1'b1,1'b0,5'd0,5'd0}, 1'b1, 1'b0, 4'd2},
        // R2 E1 produced, E1 needed
        '{'{4'd3,2'd1,4'd0,2'd0,16'h0002,2'd1,1'b0,1'b0,5'd0,5'd0},
          '{4'd0,2'd0,4'd1,2'd1,16'h0010,2'd1,1'b0,1'b0,5'd0,5'd0}, 1'b1, 1'b0, 4'd2},
        // R12 multi-cycle younger never pairs
        '{'{4'd1,2'd1,4'd0,2'd0,16'h0004,2'd1,1'b0,1'b0,5'd0,5'd0},
          '{4'd13,2'd1,4'd0,2'd0,16'h0070,2'd3,1'b1,1'b0,5'd4,5'd0}, 1'b1, 1'b0, 4'd12},
        // R8 one-register load-multiple is single cycle
        '{'{4'd13,2'd1,4'd0,2'd0,16'h0010,2'd3,1'b1,1'b0,5'd1,5'd0},
          '{4'd3,2'd1,4'd0,2'd0,16'h0004,2'd1,1'b0,1'b0,5'd0,5'd0}, 1'b1, 1'b1, 4'd8}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    desc_t da = '0, db = '0;
    logic av = 1'b0, bv = 1'b0;
    logic take_old, take_young, old_pipe, stall, hold;
    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_issue_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .a_vld(av), .a_src0(da.s0), .a_stg0(da.t0), .a_src1(da.s1), .a_stg1(da.t1),
        .a_dmask(da.dm), .a_dstg(da.dt), .a_ls(da.ls), .a_pcld(da.pc),
        .a_ldm(da.ldm), .a_shamt(da.sh),
        .b_vld(bv), .b_src0(db.s0), .b_stg0(db.t0), .b_src1(db.s1), .b_stg1(db.t1),
        .b_dmask(db.dm), .b_dstg(db.dt), .b_ls(db.ls), .b_pcld(db.pc),
        .b_ldm(db.ldm), .b_shamt(db.sh),
        .take_old(take_old), .take_young(take_young), .old_pipe(old_pipe),
        .stall(stall), .hold(hold)
    );

    task automatic chk(input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", what, act, exp, $time);
        end
    endtask

    function automatic desc_t mk(input int s0, input int t0, input int dm, input int dt,
                                 input bit ls, input bit pc, input int ldm, input int sh);
        desc_t d;
        d     = '0;
        d.s0  = 4'(s0);
        d.t0  = 2'(t0);
        d.dm  = 16'(dm);
        d.dt  = 2'(dt);
        d.ls  = ls;
        d.pc  = pc;
        d.ldm = 5'(ldm);
        d.sh  = 5'(sh);
        return d;
    endfunction

    // Next falling edge: drive slots, settle, ready to sample.
    task automatic cyc(input desc_t a, input bit a_on, input desc_t b, input bit b_on);
        @(negedge clk);
        flush = 1'b0;
        da = a; av = a_on; db = b; bv = b_on;
        #1;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1; av = 1'b0; bv = 1'b0;
        #1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        desc_t alu, ld_r0, use_r0;
        alu    = mk(3, 1, 16'h0010, 1, 0, 0, 0, 0);
        ld_r0  = mk(6, 1, 16'h0001, 3, 1, 0, 0, 0);
        use_r0 = mk(0, 1, 16'h0004, 1, 0, 0, 0, 0);

        // R11 reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R11 reset take_old", take_old, 1'b0);
        chk("R11 reset hold", hold, 1'b0);
        chk("R11 reset stall", stall, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table of pairing vectors
        for (int i = 0; i < NV; i++) begin
            do_flush();
            cyc(VECS[i].a, 1'b1, VECS[i].b, 1'b1);
            chk($sformatf("R%0d vec%0d take_old", VECS[i].rq, i), take_old, VECS[i].eo);
            chk($sformatf("R%0d vec%0d take_young", VECS[i].rq, i), take_young, VECS[i].ey);
            chk($sformatf("R1 vec%0d old_pipe", i), old_pipe, 1'b0);
        end

        // R3 E3 -> E1 two stall cycles, R10 B blocked behind stalled A
        do_flush();
        cyc(ld_r0, 1'b1, NOP, 1'b0);
        chk("R3 load issues", take_old, 1'b1);
        cyc(use_r0, 1'b1, alu, 1'b1);
        chk("R3 stall1 take", take_old, 1'b0);
        chk("R3 stall1 flag", stall, 1'b1);
        chk("R10 young blocked", take_young, 1'b0);
        cyc(use_r0, 1'b1, alu, 1'b1);
        chk("R3 stall2 take", take_old, 1'b0);
        chk("R3 stall2 flag", stall, 1'b1);
        cyc(use_r0, 1'b1, NOP, 1'b0);
        chk("R3 third cycle take", take_old, 1'b1);
        chk("R3 third cycle stall", stall, 1'b0);

        // R4 store data from E3 producer, no delay
        do_flush();
        cyc(mk(6, 1, 16'h0008, 3, 1, 0, 0, 0), 1'b1, NOP, 1'b0);
        cyc(mk(3, 3, 0, 0, 1, 0, 0, 0), 1'b1, NOP, 1'b0);
        chk("R4 store take", take_old, 1'b1);

        // R6 PC load: second cycle pairs into pipeline 1
        do_flush();
        cyc(mk(13, 1, 0, 0, 1, 1, 0, 0), 1'b1, NOP, 1'b0);
        chk("R6 pc load take", take_old, 1'b1);
        cyc(alu, 1'b1, NOP, 1'b0);
        chk("R6 hold flag", hold, 1'b1);
        chk("R6 second-cycle take", take_old, 1'b1);
        chk("R6 second-cycle pipe1", old_pipe, 1'b1);
        cyc(use_r0, 1'b1, alu, 1'b1);
        chk("R6 after hold pair old", take_old, 1'b1);
        chk("R6 after hold pair young", take_young, 1'b1);
        chk("R1 after hold pipe0", old_pipe, 1'b0);

        // R8 four-register load-multiple: 3 cycles
        do_flush();
        cyc(mk(13, 1, 16'h0070, 3, 1, 0, 4, 0), 1'b1, NOP, 1'b0);
        chk("R8 ldm take", take_old, 1'b1);
        cyc(NOP, 1'b1, NOP, 1'b0);
        chk("R8 cycle2 blocked", take_old, 1'b0);
        chk("R8 cycle2 no stall", stall, 1'b0);
        cyc(NOP, 1'b1, NOP, 1'b0);
        chk("R8 cycle3 take", take_old, 1'b1);
        chk("R8 cycle3 pipe1", old_pipe, 1'b1);

        // R9 memory op waits past last cycle
        do_flush();
        cyc(mk(13, 1, 16'h0010, 3, 1, 0, 2, 0), 1'b1, NOP, 1'b0);
        cyc(mk(1, 1, 0, 0, 1, 0, 0, 0), 1'b1, NOP, 1'b0);
        chk("R9 ls in last cycle", take_old, 1'b0);
        cyc(mk(1, 1, 0, 0, 1, 0, 0, 0), 1'b1, NOP, 1'b0);
        chk("R9 ls next cycle", take_old, 1'b1);
        chk("R9 ls pipe0", old_pipe, 1'b0);

        // R9 multi-cycle follower waits
        do_flush();
        cyc(mk(13, 1, 0, 0, 1, 1, 0, 0), 1'b1, NOP, 1'b0);
        cyc(mk(1, 1, 16'h0004, 1, 0, 0, 0, 3), 1'b1, NOP, 1'b0);
        chk("R9 multi follower held", take_old, 1'b0);
        cyc(mk(1, 1, 16'h0004, 1, 0, 0, 0, 3), 1'b1, NOP, 1'b0);
        chk("R9 multi follower pipe0 take", take_old, 1'b1);
        chk("R9 multi follower pipe0", old_pipe, 1'b0);

        // R7 shift by 1 adds a cycle
        do_flush();
        cyc(mk(1, 1, 0, 0, 1, 0, 0, 1), 1'b1, NOP, 1'b0);
        cyc(alu, 1'b1, NOP, 1'b0);
        chk("R7 shift1 hold", hold, 1'b1);
        chk("R7 shift1 follower pipe1", old_pipe, 1'b1);

        // R11 flush clears scoreboard
        do_flush();
        cyc(ld_r0, 1'b1, NOP, 1'b0);
        do_flush();
        chk("R11 flush no take", take_old, 1'b0);
        cyc(use_r0, 1'b1, NOP, 1'b0);
        chk("R11 after flush no stall", take_old, 1'b1);

        // R11 reset during hold
        do_flush();
        cyc(mk(13, 1, 0, 0, 1, 1, 0, 0), 1'b1, NOP, 1'b0);
        @(negedge clk);
        av = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R11 reset drops hold", hold, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(use_r0, 1'b1, alu, 1'b1);
        chk("R11 post-reset pair", take_young, 1'b1);
        chk("R11 post-reset pipe0", old_pipe, 1'b0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule